// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two two's-complement operands: a multiplicand of M bits and a multiplier of N bits, where N is even. The result is the full (M+N)-bit signed product. The multiplier is recoded two bits at a time into signed digits in the range −2..+2. Each digit selects a multiple of the multiplicand, so the block forms N/2 partial products. The block never needs three times the multiplicand.

A negative partial product is the inverted multiple plus a single 1 at that row's least significant column. All of those 1s share one correction row. Sign extension is not built row by row. Each row's top bit is inverted instead, and a single constant, computed at elaboration, cancels the offsets. A linear chain of carry-save adders reduces the rows to a sum row and a carry row. One carry-propagate adder then resolves the two.

A parameter adds an optional output register with an active-low asynchronous reset. With the parameter at zero the block is purely combinational from operands to product.

Top module: `booth_mul`

## Requirements
- R1: `product_o` equals the signed product of `a_i` and `b_i`, both read as two's complement, as an (M+N)-bit two's-complement value, for every operand pair.
- R2: The most negative multiplicand times the most negative multiplier gives +2^(M+N−2), with the top bit of `product_o` equal to 0.
- R3: Multiplier bit triplets (b[2i+1], b[2i], b[2i−1]), with b[−1]=0, map to digits as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives −2; 101 and 110 give −1. Multipliers of all ones (−1), 1, 2, 3 and −2 produce −a, a, 2a, 3a and −2a.
- R4: A zero operand on either side gives a zero product, whatever the other operand holds.
- R5: With OUT_REG=1, `product_o` takes the product of the operands present at a rising edge of `clk_i`, and holds that value until the next rising edge, even when the operands change.
- R6: With OUT_REG=1, `rst_ni` low clears `product_o` to 0 at once, without waiting for a clock edge.
- R7: For the 16×16 default widths, products of sampled operand pairs match the signed reference, including both sign extremes crossed with −1 and +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | M | Multiplicand, two's complement |
| b_i | input | N | Multiplier, two's complement, Booth recoded |
| product_o | output | M+N | Signed product |

## Verification
The datapath keeps no state, so a wrong digit decode, a misplaced correction bit or a bad sign-extension constant shows on `product_o` in the same evaluation as the operands that trigger it. With the register enabled, it shows one clock edge later. A wrong constant offsets every product by a fixed amount. A wrong decode or a misplaced correction bit corrupts only the operand pairs whose triplets hit that entry. The exhaustive 8×8 sweep visits every triplet in every digit position, and the sign extremes exercise the top row's extension.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef struct packed {
    logic neg;  // subtract the selected multiple
    logic one;  // select 1x multiplicand
    logic two;  // select 2x multiplicand
  } booth_ctl_t;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pkg::*;
(
  input  logic [2:0] trip_i,
  output booth_ctl_t ctl_o
);
  always_comb begin
    ctl_o.one = trip_i[1] ^ trip_i[0];
    ctl_o.two = (trip_i == 3'b011) || (trip_i == 3'b100);
    ctl_o.neg = trip_i[2] & ~(trip_i[1] & trip_i[0]);  // 111 is +0, not -0
  end
endmodule

// File: rtl/booth_sel.sv
module booth_sel
  import booth_pkg::*;
#(
  parameter int M = 16
) (
  input  logic [M-1:0] y_i,
  input  booth_ctl_t   ctl_i,
  output logic [M:0]   pp_o
);
  logic [M:0] mult;

  always_comb begin
    unique case ({ctl_i.two, ctl_i.one})
      2'b01:   mult = {y_i[M-1], y_i};
      2'b10:   mult = {y_i, 1'b0};
      default: mult = '0;
    endcase
    pp_o = mult ^ {(M+1){ctl_i.neg}};
  end
endmodule

// File: rtl/booth_csa_chain.sv
module booth_csa_chain #(
  parameter int W = 32,
  parameter int K = 10
) (
  input  logic [W-1:0] rows_i [K],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  localparam int S = K - 2;

  logic [W-1:0] s_w [S];
  logic [W-1:0] c_w [S];

  for (genvar j = 0; j < S; j++) begin : g_stage
    logic [W-1:0] x, y, z;
    if (j == 0) begin : g_first
      assign x = rows_i[0];
      assign y = rows_i[1];
    end else begin : g_next
      assign x = s_w[j-1];
      assign y = c_w[j-1];
    end
    assign z = rows_i[j+2];
    assign s_w[j] = x ^ y ^ z;
    assign c_w[j] = {((x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) |
                      (y[W-2:0] & z[W-2:0])), 1'b0};
  end

  assign sum_o   = s_w[S-1];
  assign carry_o = c_w[S-1];
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int M       = 16,
  parameter int N       = 16,
  parameter bit OUT_REG = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [M+N-1:0] product_o
);
  localparam int W = M + N;
  localparam int P = N / 2;
  localparam int K = P + 2;

  // offset that cancels the inverted-sign trick of every row
  function automatic logic [W-1:0] sext_const();
    logic [W-1:0] k;
    k = '0;
    for (int i = 0; i < P; i++) k = k - (W'(1) << (M + 2*i));
    return k;
  endfunction
  localparam logic [W-1:0] SEXT_K = sext_const();

  logic [N:0]   bx;
  booth_ctl_t   ctl_w [P];
  logic [M:0]   pp_w  [P];
  logic [W-1:0] rows  [K];
  logic [W-1:0] neg_row;
  logic [W-1:0] csa_s, csa_c, prod_comb;

  assign bx = {b_i, 1'b0};

  for (genvar i = 0; i < P; i++) begin : g_row
    booth_enc u_enc (
      .trip_i (bx[2*i+2:2*i]),
      .ctl_o  (ctl_w[i])
    );
    booth_sel #(.M(M)) u_sel (
      .y_i   (a_i),
      .ctl_i (ctl_w[i]),
      .pp_o  (pp_w[i])
    );
    assign rows[i] = W'({~pp_w[i][M], pp_w[i][M-1:0]}) << (2*i);

    // R3: at most one magnitude selected; sign only with nonzero digit
    p_digit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({ctl_w[i].one, ctl_w[i].two}) &&
      (!ctl_w[i].neg || ctl_w[i].one || ctl_w[i].two));
  end

  always_comb begin
    neg_row = '0;
    for (int i = 0; i < P; i++) neg_row[2*i] = ctl_w[i].neg;
  end

  assign rows[P]   = neg_row;
  assign rows[P+1] = SEXT_K;

  booth_csa_chain #(.W(W), .K(K)) u_csa (
    .rows_i  (rows),
    .sum_o   (csa_s),
    .carry_o (csa_c)
  );

  assign prod_comb = csa_s + csa_c;

  if (OUT_REG) begin : g_reg
    logic primed;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        product_o <= '0;
        primed    <= 1'b0;
      end else begin
        product_o <= prod_comb;
        primed    <= 1'b1;
      end
    end

    p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed |-> product_o == $past(prod_comb));
    p_reset_r6: assert property (@(posedge clk_i) !rst_ni |-> product_o == '0);
  end else begin : g_comb
    assign product_o = prod_comb;
  end

  // reference checks against a plain signed multiply
  logic [W-1:0] ref_w, rows_total;
  assign ref_w = $signed({{N{a_i[M-1]}}, a_i}) * $signed({{M{b_i[N-1]}}, b_i});

  always_comb begin
    rows_total = '0;
    for (int i = 0; i < K; i++) rows_total = rows_total + rows[i];
  end

  p_rows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rows_total == ref_w);
  p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_comb == ref_w);
  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |-> prod_comb == '0);
endmodule

// File: tb/tb_booth_mul.sv
`timescale 1ns/1ps
module tb_booth_mul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [31:0] p16;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  booth_mul #(.M(16), .N(16), .OUT_REG(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a16), .b_i(b16), .product_o(p16));

  booth_mul #(.M(8), .N(8), .OUT_REG(1'b0)) dut8 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a8), .b_i(b8), .product_o(p8));

  function automatic logic [31:0] ref16(logic [15:0] a, logic [15:0] b);
    int x, y;
    x = int'($signed(a));
    y = int'($signed(b));
    return 32'(x * y);
  endfunction

  function automatic logic [15:0] ref8(logic [7:0] a, logic [7:0] b);
    int x, y;
    x = int'($signed(a));
    y = int'($signed(b));
    return 16'(x * y);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // registered 16x16: drive at negedge, sample at the following negedge
  task automatic mul16(string req, logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    a16 = a;
    b16 = b;
    @(negedge clk);
    check(req, p16, ref16(a, b));
  endtask

  task automatic t_reset();
    check("R6 reset state", p16, 32'h0);
    rst_n = 1'b1;
    mul16("R6 prep", 16'h1234, 16'h0FED);
    #2 rst_n = 1'b0;
    #1 check("R6 async clear", p16, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_exhaustive8();
    int bad;
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        a8 = 8'(i);
        b8 = 8'(j);
        #1;
        if (p8 !== ref8(a8, b8)) begin
          if (bad < 4) check("R1 exhaustive 8x8", {16'h0, p8}, {16'h0, ref8(a8, b8)});
          bad++;
        end
      end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R1 exhaustive mismatches actual=%0d expected=0", bad);
    end
    a8 = 8'h80; b8 = 8'h80; #1;
    check("R2 8x8 min*min", {16'h0, p8}, 32'h0000_4000);
  endtask

  task automatic t_digits();
    mul16("R3 b=-1", 16'h1357, 16'hFFFF);
    mul16("R3 b=1",  16'hA5C3, 16'h0001);
    mul16("R3 b=2",  16'h7001, 16'h0002);
    mul16("R3 b=3",  16'h4321, 16'h0003);
    mul16("R3 b=-2", 16'h0F0F, 16'hFFFE);
    mul16("R3 alternating", 16'h6B2D, 16'h5555);
    mul16("R3 alternating neg", 16'h9ACE, 16'hAAAA);
  endtask

  task automatic t_zero();
    mul16("R4 a zero", 16'h0000, 16'h8001);
    mul16("R4 b zero", 16'hFFFF, 16'h0000);
  endtask

  task automatic t_corners();
    mul16("R2 min*min", 16'h8000, 16'h8000);
    check("R2 value", p16, 32'h4000_0000);
    mul16("R7 min*-1", 16'h8000, 16'hFFFF);
    mul16("R7 max*-1", 16'h7FFF, 16'hFFFF);
    mul16("R7 max*max", 16'h7FFF, 16'h7FFF);
    mul16("R7 min*1",  16'h8000, 16'h0001);
    mul16("R7 -1*min", 16'hFFFF, 16'h8000);
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++)
      mul16("R7 random 16x16", 16'($urandom), 16'($urandom));
  endtask

  task automatic t_latency();
    @(negedge clk);
    a16 = 16'h0123; b16 = 16'h0456;
    @(negedge clk);
    a16 = 16'hF00D; b16 = 16'h0BAD;
    #2 check("R5 hold before edge", p16, ref16(16'h0123, 16'h0456));
    @(negedge clk);
    check("R5 update after edge", p16, ref16(16'hF00D, 16'h0BAD));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_exhaustive8();
    t_digits();
    t_zero();
    t_corners();
    t_latency();
    t_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule